// File: doc/BRIEF.md
# Foreground Interstage Gain Trim Sequencer

This controller runs a one-shot foreground calibration of the interstage gain of the first three residue stages of a pipelined converter. Each stage gets a 7-bit trim code, which sets the size of a feedback-adjust capacitor. The code is found by successive approximation against a single comparator. While a stage is under test, the front end feeds it a fixed one-eighth-reference input. At the correct gain of four, its output sits at half reference, which is the comparator threshold. The comparator bit reports whether the output lies above that point. A larger code is taken to raise the gain.

Stages are trimmed from the back toward the input. Each finished stage then acts as an ideal reference while the stage in front of it is measured. Later stages are never trimmed. A single start pulse launches the whole run, which ends 168 cycles later:

- 3 stages, each with 7 bits.
- 8 cycles per bit: one apply cycle, six settling cycles, and one comparator sampling cycle.

The stage select output, the phase output and the calibration-mode flag tell the analog side which stage to configure and when its output is valid.

Top module: `gcal_seq`

## Requirements
- R1: After synchronous reset, every trim code is midscale (64), and `busy_o`, `done_o` and `cal_mode_o` are low.
- R2: A start pulse sampled while idle raises `busy_o` and `cal_mode_o` in the next cycle, with `stage_sel_o` = 2.
- R3: Stages are calibrated in the order 2, 1, 0, for 56 cycles each. After the start edge k (k = 0..167), `stage_sel_o` equals 2 − k/56.
- R4: Each bit takes 8 cycles. `phase_o` encodes the phase as apply = 0, settle = 1, sample = 2. The cycles run apply once, settle six times, then sample once.
- R5: Bits are decided from MSB to LSB. At the end of the apply cycle the trial bit is set to 1; on the MSB the lower bits are also cleared. On the sample edge the bit is cleared if `cmp_above_i` is 1 and kept if it is 0. With a comparator that reports above whenever code > T, the final code equals T, including T = 0 and T = 127.
- R6: During calibration only the selected stage's code changes. The other codes hold.
- R7: `done_o` is a one-cycle pulse, high in the 168th cycle after the start edge. `busy_o` falls in that same cycle.
- R8: A start pulse while busy is ignored, and the run's stage and phase timing is unaffected.
- R9: While idle, the trim codes hold their values regardless of `cmp_above_i`, until the next start.
- R10: The code of stage s sits at bits [7s+6:7s] of `trim_o`. A new run overwrites all three codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Calibration start pulse |
| cmp_above_i | input | 1 | Comparator: stage output above half reference |
| trim_o | output | 21 | Packed trim codes, stage s at [7s+6:7s] |
| stage_sel_o | output | 2 | Stage configured for test |
| phase_o | output | 2 | Bit phase: 0 apply, 1 settle, 2 sample |
| cal_mode_o | output | 1 | Front end in calibration configuration |
| busy_o | output | 1 | Calibration running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bound checker watches the following on every cycle:
- the phase order within a bit;
- that the stage select never increases during a run;
- the shape of the done pulse and its coincidence with the fall of busy;
- that codes hold while idle.

Only the bench scenarios can show the values the codes converge to, the exact 168-cycle budget, and that a start pulse in mid-run is ignored. The bench does this with a comparator model that holds per-stage target codes, including the extremes 0 and 127, and with repeated runs that must overwrite earlier results.

// File: rtl/gcal_pkg.sv
package gcal_pkg;

    localparam int NSTAGE_DEF = 3;
    localparam int CODE_W_DEF = 7;
    localparam int SETTLE_DEF = 6;

    typedef enum logic [1:0] {
        PH_APPLY  = 2'd0,
        PH_SETTLE = 2'd1,
        PH_SAMPLE = 2'd2
    } phase_e;

    function automatic logic [CODE_W_DEF-1:0] midscale();
        logic [CODE_W_DEF-1:0] m;
        m = '0;
        m[CODE_W_DEF-1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/gcal_timer.sv
module gcal_timer
    import gcal_pkg::*;
#(
    parameter int NSTAGE = NSTAGE_DEF,
    parameter int CODE_W = CODE_W_DEF,
    parameter int SETTLE = SETTLE_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    output logic                      busy_o,
    output logic [$clog2(NSTAGE)-1:0] stage_o,
    output logic [$clog2(CODE_W)-1:0] bit_o,
    output phase_e                    phase_o,
    output logic                      finish_o
);
    localparam int BIT_CYC = SETTLE + 2;
    localparam int CNT_W   = $clog2(BIT_CYC);
    localparam int STG_W   = $clog2(NSTAGE);
    localparam int BIT_W   = $clog2(CODE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            stage_o <= '0;
            bit_o   <= '0;
            cnt     <= '0;
        end else if (!busy_o) begin
            if (start_i) begin
                busy_o  <= 1'b1;
                stage_o <= STG_W'(NSTAGE - 1);
                bit_o   <= BIT_W'(CODE_W - 1);
                cnt     <= '0;
            end
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (bit_o == '0) begin
                bit_o <= BIT_W'(CODE_W - 1);
                if (stage_o == '0) begin
                    busy_o <= 1'b0;
                end else begin
                    stage_o <= stage_o - 1'b1;
                end
            end else begin
                bit_o <= bit_o - 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        if (cnt == '0)           phase_o = PH_APPLY;
        else if (cnt == CNT_LAST) phase_o = PH_SAMPLE;
        else                      phase_o = PH_SETTLE;
    end

    assign finish_o = busy_o && (cnt == CNT_LAST) && (bit_o == '0) && (stage_o == '0);

endmodule

// File: rtl/gcal_trim_bank.sv
module gcal_trim_bank
    import gcal_pkg::*;
#(
    parameter int NSTAGE = NSTAGE_DEF,
    parameter int CODE_W = CODE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       apply_i,
    input  logic                       sample_i,
    input  logic                       above_i,
    input  logic [$clog2(NSTAGE)-1:0]  stage_i,
    input  logic [$clog2(CODE_W)-1:0]  bit_i,
    output logic [NSTAGE*CODE_W-1:0]   trim_o
);
    localparam int BIT_W = $clog2(CODE_W);
    localparam logic [BIT_W-1:0] MSB = BIT_W'(CODE_W - 1);

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        logic [CODE_W-1:0] code;
        logic              sel;

        assign sel = (int'(stage_i) == g);

        always_ff @(posedge clk) begin
            if (rst) begin
                code <= midscale();
            end else if (sel && apply_i) begin
                if (bit_i == MSB) begin
                    code <= midscale();
                end else begin
                    code[bit_i] <= 1'b1;
                end
            end else if (sel && sample_i && above_i) begin
                code[bit_i] <= 1'b0;
            end
        end

        assign trim_o[g*CODE_W +: CODE_W] = code;
    end

endmodule

// File: rtl/gcal_seq.sv
module gcal_seq
    import gcal_pkg::*;
#(
    parameter int NSTAGE = NSTAGE_DEF,
    parameter int CODE_W = CODE_W_DEF,
    parameter int SETTLE = SETTLE_DEF
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic                      cmp_above_i,
    output logic [NSTAGE*CODE_W-1:0]  trim_o,
    output logic [$clog2(NSTAGE)-1:0] stage_sel_o,
    output logic [1:0]                phase_o,
    output logic                      cal_mode_o,
    output logic                      busy_o,
    output logic                      done_o
);
    localparam int BIT_W = $clog2(CODE_W);

    logic             busy;
    logic [BIT_W-1:0] bitpos;
    phase_e           phase;
    logic             finish;

    gcal_timer #(
        .NSTAGE(NSTAGE),
        .CODE_W(CODE_W),
        .SETTLE(SETTLE)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .busy_o   (busy),
        .stage_o  (stage_sel_o),
        .bit_o    (bitpos),
        .phase_o  (phase),
        .finish_o (finish)
    );

    gcal_trim_bank #(
        .NSTAGE(NSTAGE),
        .CODE_W(CODE_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .apply_i  (busy && phase == PH_APPLY),
        .sample_i (busy && phase == PH_SAMPLE),
        .above_i  (cmp_above_i),
        .stage_i  (stage_sel_o),
        .bit_i    (bitpos),
        .trim_o   (trim_o)
    );

    always_ff @(posedge clk) begin
        if (rst) done_o <= 1'b0;
        else     done_o <= finish;
    end

    assign busy_o     = busy;
    assign cal_mode_o = busy;
    assign phase_o    = phase;

endmodule

// File: rtl/gcal_seq_chk.sv
module gcal_seq_chk #(
    parameter int NSTAGE = 3,
    parameter int CODE_W = 7
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start_i,
    input logic [NSTAGE*CODE_W-1:0]  trim_o,
    input logic [$clog2(NSTAGE)-1:0] stage_sel_o,
    input logic [1:0]                phase_o,
    input logic                      busy_o,
    input logic                      done_o
);
    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && int'(stage_sel_o) == NSTAGE - 1));

    // R3
    stage_order_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> (stage_sel_o <= $past(stage_sel_o)));

    // R4
    apply_then_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && phase_o == 2'd0) |=> (phase_o == 2'd1));

    // R4
    sample_then_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && phase_o == 2'd2) |=> (phase_o == 2'd0 || !busy_o));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    done_with_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(trim_o));

endmodule

bind gcal_seq gcal_seq_chk #(
    .NSTAGE(NSTAGE),
    .CODE_W(CODE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .trim_o      (trim_o),
    .stage_sel_o (stage_sel_o),
    .phase_o     (phase_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/gcal_seq_test.sv
module gcal_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        cmp;
    logic [20:0] trim;
    logic [1:0]  ssel;
    logic [1:0]  ph;
    logic        cal;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int tgt [3];

    always #5 clk = ~clk;

    gcal_seq uut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .cmp_above_i (cmp),
        .trim_o      (trim),
        .stage_sel_o (ssel),
        .phase_o     (ph),
        .cal_mode_o  (cal),
        .busy_o      (busy),
        .done_o      (done)
    );

    // Analog model: output above target when code exceeds the stage target; noise while idle.
    always @(negedge clk) begin
        if (busy && ssel < 2'd3) cmp = (int'(trim[int'(ssel)*7 +: 7]) > tgt[int'(ssel)]);
        else                     cmp = 1'($urandom);
    end

    function automatic int code_of(int s);
        return int'(trim[s*7 +: 7]);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int s = 0; s < 3; s++) chk(code_of(s) == 64, "R1 trim midscale", code_of(s), 64);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(cal == 1'b0, "R1 cal_mode", int'(cal), 0);
    endtask

    task automatic t_run(int t2, int t1, int t0, int glitch_at);
        int bad_stage, bad_phase, bad_busy, bad_hold, bad_idle;
        int prev_code [3];
        int prev_sel;
        tgt[2] = t2; tgt[1] = t1; tgt[0] = t0;
        bad_stage = 0; bad_phase = 0; bad_busy = 0; bad_hold = 0; bad_idle = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && cal && ssel == 2'd2, "R2 launch", int'({busy, cal, ssel}), 4'b1110);
        prev_sel = 2;
        for (int s = 0; s < 3; s++) prev_code[s] = code_of(s);
        for (int k = 0; k < 168; k++) begin
            int es, ep;
            es = 2 - k / 56;
            ep = (k % 8 == 0) ? 0 : ((k % 8 == 7) ? 2 : 1);
            if (int'(ssel) != es) bad_stage++;
            if (int'(ph) != ep) bad_phase++;
            if (!busy || !cal || done) bad_busy++;
            for (int s = 0; s < 3; s++)
                if (s != int'(ssel) && s != prev_sel && code_of(s) != prev_code[s]) bad_hold++;
            prev_sel = int'(ssel);
            for (int s = 0; s < 3; s++) prev_code[s] = code_of(s);
            start = (k == glitch_at);
            @(negedge clk);
            start = 1'b0;
        end
        chk(bad_stage == 0, "R3 stage order", bad_stage, 0);
        chk(bad_phase == 0, (glitch_at >= 0) ? "R8 phase after ignored start" : "R4 phase", bad_phase, 0);
        chk(bad_busy == 0, "R7 busy through run", bad_busy, 0);
        chk(bad_hold == 0, "R6 unselected codes hold", bad_hold, 0);
        chk(done == 1'b1 && busy == 1'b0, "R7 done at cycle 168", int'({done, busy}), 2);
        for (int s = 0; s < 3; s++)
            chk(code_of(s) == tgt[s], "R5 R10 final code", code_of(s), tgt[s]);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
        for (int s = 0; s < 3; s++) prev_code[s] = code_of(s);
        repeat (20) begin
            @(negedge clk);
            for (int s = 0; s < 3; s++) if (code_of(s) != prev_code[s]) bad_idle++;
            if (busy) bad_idle++;
        end
        chk(bad_idle == 0, "R9 idle hold", bad_idle, 0);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cmp = 1'b0;
        tgt[0] = 0; tgt[1] = 0; tgt[2] = 0;
        t_reset();
        t_run(93, 37, 70, -1);
        t_run(0, 127, 64, -1);     // R5 extremes, R10 overwrite
        t_run(85, 42, 1, 30);      // R8 start while busy
        t_run(126, 63, 5, 100);    // R8 again in second stage, R10 rerun
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule